// File: doc/BRIEF.md
# Hot Pool Sequential Block Manager

This block looks after the physical flash blocks that hold write-hot data in a flash controller. The pool is a contiguous range of physical block IDs. It starts at a base block and holds a fixed number of blocks, and this number never exceeds the over-provisioned block count. Page-write requests are granted in strict order. Each block is filled page by page, and then the next block ID in the pool is opened. After the last slot the pool wraps back to its first slot. The garbage-collection victim is always the oldest filled block, and it moves through the pool in the same ring order. Because writes and erases both sweep the pool in order, every block collects the same number of program/erase cycles, and no separate wear-leveling logic exists.

The block counts accepted erases of hot blocks. While the device is in its refresh phase and this count has reached a fixed interval (1024 by default), the block asks for the whole pool to move onto the next set of physical blocks. It raises a one-cycle request that carries the old base and the new base. The new base is the old base plus the pool size, modulo the device's total block count. Outside the refresh phase no move is ever requested. Data movement is done externally, and an acknowledge completes the move.

Top module: `hot_pool_mgr`

## Requirements
- R1: After reset, allocGnt, rotReq, rotPending and gcReq are low, gcVictim equals BASE_INIT, and the first granted page is page 0 of block BASE_INIT.
- R2: An allocReq seen while the pool is not full is answered in the next cycle by allocGnt high for one cycle, with allocBlock = (base + slot) mod TOTAL_BLOCKS and allocPage = page. Pages ascend from 0 to PAGES_PER_BLOCK-1 within a block, and then the next slot is opened.
- R3: After the last slot (POOL_BLOCKS-1), allocation wraps to slot 0, which is block number base.
- R4: gcVictim is (base + oldest filled slot) mod TOTAL_BLOCKS. Each accepted eraseDone advances it by one slot in ring order and frees that block.
- R5: gcReq is high exactly when no erased block remains beyond the open one. This is when all POOL_BLOCKS blocks are full, or when POOL_BLOCKS-1 blocks are full and the open block holds at least one page.
- R6: While all POOL_BLOCKS blocks are full, allocReq gets no grant. Allocation resumes after an erase.
- R7: eraseDone while no block is full is ignored: gcVictim does not move and no program/erase cycle is counted.
- R8: Accepted erases are counted, and the count saturates at PE_INTERVAL. While refreshPhase is low, rotReq never rises.
- R9: When refreshPhase is high, the count is at PE_INTERVAL and no move is pending, rotReq pulses for one cycle and rotPending rises and stays high until rotAck.
- R10: rotOldBase shows the current base, and rotNewBase shows (base + POOL_BLOCKS) mod TOTAL_BLOCKS. A rotAck while a move is pending makes the new base current and restarts the erase count. A rotAck with no pending move is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocReq | input | 1 | Request for one hot page |
| allocGnt | output | 1 | Grant, one cycle after an accepted request |
| allocBlock | output | BLK_W | Physical block of the granted page |
| allocPage | output | PAGE_W | Page offset of the granted page |
| gcReq | output | 1 | No spare erased block remains |
| gcVictim | output | BLK_W | Physical block to collect next |
| eraseDone | input | 1 | The victim block has been erased |
| refreshPhase | input | 1 | High in the refresh phase |
| rotReq | output | 1 | One-cycle pulse asking for a pool move |
| rotOldBase | output | BLK_W | Current pool base |
| rotNewBase | output | BLK_W | Base after the move |
| rotPending | output | 1 | A move is awaiting acknowledge |
| rotAck | input | 1 | The move is complete |

## Verification
The hardest cases to reach are the ones where several counters meet in the same cycle. One is a grant that fills the last free block arriving together with an erase. Another is an acknowledge that coincides with an erase, which must leave the restarted count at one rather than zero. A third is a base that wraps modulo the block count across successive moves. The bench uses a small configuration: 16 blocks, a 4-block pool starting at 10, 4 pages per block and an interval of 8. It first fills the pool until allocation stalls. It then runs long deterministic request, erase and acknowledge patterns whose erase rate alternates between slow and fast. This reaches full-pool stalls and about a dozen pool moves, and the base steps through 10, 14, 2 and 6. Every output is compared each cycle against an arithmetic model.

// File: rtl/hp_pkg.sv
package hp_pkg;

  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic grant;      // hand out the current page
    logic advance;    // the granted page closes the open block
    logic erase;      // accepted erase of the oldest full block
    logic rotFire;    // launch a pool move request
    logic rotCommit;  // pending move acknowledged, adopt new base
  } hpStrobe_t;

endpackage

// File: rtl/hp_ctrl.sv
module hp_ctrl
  import hp_pkg::*;
#(
  parameter int POOL_BLOCKS = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      allocReq,
  input  logic      eraseDone,
  input  logic      refreshPhase,
  input  logic      rotAck,
  input  logic      poolFull,
  input  logic      poolNearFull,
  input  logic      openUsed,
  input  logic      noneFull,
  input  logic      lastPage,
  input  logic      peSat,
  output hpStrobe_t strobe,
  output logic      gcReq,
  output logic      rotReq,
  output logic      rotPending
);

  logic rotReqQ;
  logic pendQ;

  always_comb begin
    strobe           = '0;
    strobe.grant     = allocReq && !poolFull;
    strobe.advance   = strobe.grant && lastPage;
    strobe.erase     = eraseDone && !noneFull;
    strobe.rotFire   = refreshPhase && peSat && !pendQ;
    strobe.rotCommit = rotAck && pendQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rotReqQ <= 1'b0;
      pendQ   <= 1'b0;
    end else begin
      rotReqQ <= strobe.rotFire;
      if (strobe.rotFire)        pendQ <= 1'b1;
      else if (strobe.rotCommit) pendQ <= 1'b0;
    end
  end

  assign gcReq      = poolFull || (poolNearFull && openUsed);
  assign rotReq     = rotReqQ;
  assign rotPending = pendQ;

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rotReq |=> !rotReq);
  a_r9_pending_held: assert property (@(posedge clk) disable iff (!rstN)
    (rotPending && !rotAck) |=> rotPending);
  a_r8_no_move_prerefresh: assert property (@(posedge clk) disable iff (!rstN)
    !refreshPhase |=> !rotReq);
  a_r9_pulse_sets_pending: assert property (@(posedge clk) disable iff (!rstN)
    rotReq |-> rotPending);

endmodule

// File: rtl/hp_dpath.sv
module hp_dpath
  import hp_pkg::*;
#(
  parameter int TOTAL_BLOCKS    = 64,
  parameter int POOL_BLOCKS     = 8,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int PE_INTERVAL     = 1024,
  parameter int BASE_INIT       = 0,
  localparam int BLK_W  = $clog2(TOTAL_BLOCKS),
  localparam int IDX_W  = $clog2(POOL_BLOCKS),
  localparam int CNT_W  = $clog2(POOL_BLOCKS + 1),
  localparam int PAGE_W = $clog2(PAGES_PER_BLOCK),
  localparam int PE_W   = $clog2(PE_INTERVAL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  hpStrobe_t         strobe,
  output logic              poolFull,
  output logic              poolNearFull,
  output logic              openUsed,
  output logic              noneFull,
  output logic              lastPage,
  output logic              peSat,
  output logic              allocGnt,
  output logic [BLK_W-1:0]  allocBlock,
  output logic [PAGE_W-1:0] allocPage,
  output logic [BLK_W-1:0]  gcVictim,
  output logic [BLK_W-1:0]  rotOldBase,
  output logic [BLK_W-1:0]  rotNewBase
);

  localparam logic [BLK_W:0]  TOTAL_L  = (BLK_W+1)'(TOTAL_BLOCKS);
  localparam logic [BLK_W:0]  POOL_OFF = (BLK_W+1)'(POOL_BLOCKS);
  localparam logic [CNT_W-1:0] POOL_C  = CNT_W'(POOL_BLOCKS);
  localparam logic [PE_W-1:0]  PE_LIM  = PE_W'(PE_INTERVAL);

  logic [IDX_W-1:0]  wrIdx, gcIdx;
  logic [PAGE_W-1:0] wrPage;
  logic [CNT_W-1:0]  fullCnt;
  logic [PE_W-1:0]   peCnt;
  logic [BLK_W-1:0]  baseQ;
  logic              gntQ;
  logic [BLK_W-1:0]  blkQ;
  logic [PAGE_W-1:0] pageQ;

  // Add an offset to a block ID, wrapping at the device block count
  function automatic logic [BLK_W-1:0] wrapAdd(input logic [BLK_W-1:0] b,
                                                input logic [BLK_W:0] off);
    logic [BLK_W:0] s;
    s = {1'b0, b} + off;
    if (s >= TOTAL_L) s = s - TOTAL_L;
    return s[BLK_W-1:0];
  endfunction

  logic [IDX_W-1:0] wrIdxNext, gcIdxNext;

  // Ring step: a power-of-two pool wraps by truncation, others by compare
  generate
    if ((1 << IDX_W) == POOL_BLOCKS) begin : g_ring_pow2
      assign wrIdxNext = wrIdx + 1'b1;
      assign gcIdxNext = gcIdx + 1'b1;
    end else begin : g_ring_cmp
      assign wrIdxNext = (wrIdx == IDX_W'(POOL_BLOCKS - 1)) ? '0 : wrIdx + 1'b1;
      assign gcIdxNext = (gcIdx == IDX_W'(POOL_BLOCKS - 1)) ? '0 : gcIdx + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx   <= '0;
      wrPage  <= '0;
      gcIdx   <= '0;
      fullCnt <= '0;
      peCnt   <= '0;
      baseQ   <= BLK_W'(BASE_INIT);
      gntQ    <= 1'b0;
      blkQ    <= '0;
      pageQ   <= '0;
    end else begin
      gntQ <= strobe.grant;
      if (strobe.grant) begin
        blkQ  <= wrapAdd(baseQ, (BLK_W+1)'(wrIdx));
        pageQ <= wrPage;
        if (strobe.advance) begin
          wrPage <= '0;
          wrIdx  <= wrIdxNext;
        end else begin
          wrPage <= wrPage + 1'b1;
        end
      end
      if (strobe.erase) gcIdx <= gcIdxNext;
      case ({strobe.advance, strobe.erase})
        2'b10:   fullCnt <= fullCnt + 1'b1;
        2'b01:   fullCnt <= fullCnt - 1'b1;
        default: fullCnt <= fullCnt;
      endcase
      if (strobe.rotCommit) begin
        baseQ <= rotNewBase;
        peCnt <= strobe.erase ? PE_W'(1) : '0;
      end else if (strobe.erase && !peSat) begin
        peCnt <= peCnt + 1'b1;
      end
    end
  end

  assign poolFull     = (fullCnt == POOL_C);
  assign poolNearFull = (fullCnt == POOL_C - 1'b1);
  assign noneFull     = (fullCnt == '0);
  assign openUsed     = (wrPage != '0);
  assign lastPage     = (wrPage == PAGE_W'(PAGES_PER_BLOCK - 1));
  assign peSat        = (peCnt == PE_LIM);
  assign allocGnt     = gntQ;
  assign allocBlock   = blkQ;
  assign allocPage    = pageQ;
  assign gcVictim     = wrapAdd(baseQ, (BLK_W+1)'(gcIdx));
  assign rotOldBase   = baseQ;
  assign rotNewBase   = wrapAdd(baseQ, POOL_OFF);

  a_r6_no_grant_full: assert property (@(posedge clk) disable iff (!rstN)
    allocGnt |-> $past(fullCnt) != POOL_C);
  a_r4_full_bound: assert property (@(posedge clk) disable iff (!rstN)
    fullCnt <= POOL_C);
  a_r7_idle_erase: assert property (@(posedge clk) disable iff (!rstN)
    (noneFull && !strobe.advance) |=> $stable(gcIdx));
  a_r10_base_steady: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rotCommit |=> $stable(baseQ));
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    peCnt <= PE_LIM);

endmodule

// File: rtl/hot_pool_mgr.sv
module hot_pool_mgr
  import hp_pkg::*;
#(
  parameter int TOTAL_BLOCKS    = 64,
  parameter int OVERPROV_BLOCKS = 8,
  parameter int POOL_BLOCKS     = 8,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int PE_INTERVAL     = 1024,
  parameter int BASE_INIT       = 0,
  localparam int BLK_W  = $clog2(TOTAL_BLOCKS),
  localparam int PAGE_W = $clog2(PAGES_PER_BLOCK)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocReq,
  output logic              allocGnt,
  output logic [BLK_W-1:0]  allocBlock,
  output logic [PAGE_W-1:0] allocPage,
  output logic              gcReq,
  output logic [BLK_W-1:0]  gcVictim,
  input  logic              eraseDone,
  input  logic              refreshPhase,
  output logic              rotReq,
  output logic [BLK_W-1:0]  rotOldBase,
  output logic [BLK_W-1:0]  rotNewBase,
  output logic              rotPending,
  input  logic              rotAck
);

  generate
    if (POOL_BLOCKS > OVERPROV_BLOCKS || POOL_BLOCKS < 2 ||
        POOL_BLOCKS > TOTAL_BLOCKS || BASE_INIT >= TOTAL_BLOCKS ||
        PAGES_PER_BLOCK < 2 || PE_INTERVAL < 1) begin : g_bad_cfg
      $error("hot_pool_mgr: invalid parameter set");
    end
  endgenerate

  hpStrobe_t strobe;
  logic poolFull, poolNearFull, openUsed, noneFull, lastPage, peSat;

  hp_ctrl #(.POOL_BLOCKS(POOL_BLOCKS)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .allocReq(allocReq), .eraseDone(eraseDone),
    .refreshPhase(refreshPhase), .rotAck(rotAck),
    .poolFull(poolFull), .poolNearFull(poolNearFull),
    .openUsed(openUsed), .noneFull(noneFull),
    .lastPage(lastPage), .peSat(peSat),
    .strobe(strobe), .gcReq(gcReq),
    .rotReq(rotReq), .rotPending(rotPending)
  );

  hp_dpath #(
    .TOTAL_BLOCKS(TOTAL_BLOCKS), .POOL_BLOCKS(POOL_BLOCKS),
    .PAGES_PER_BLOCK(PAGES_PER_BLOCK), .PE_INTERVAL(PE_INTERVAL),
    .BASE_INIT(BASE_INIT)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .poolFull(poolFull), .poolNearFull(poolNearFull),
    .openUsed(openUsed), .noneFull(noneFull),
    .lastPage(lastPage), .peSat(peSat),
    .allocGnt(allocGnt), .allocBlock(allocBlock), .allocPage(allocPage),
    .gcVictim(gcVictim), .rotOldBase(rotOldBase), .rotNewBase(rotNewBase)
  );

endmodule

// File: tb/test_hot_pool_mgr.sv
module test_hot_pool_mgr;

  localparam int T   = 16;
  localparam int N   = 4;
  localparam int PPB = 4;
  localparam int INT = 8;
  localparam int B0  = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocReq = 1'b0, eraseDone = 1'b0, refreshPhase = 1'b0, rotAck = 1'b0;
  logic allocGnt, gcReq, rotReq, rotPending;
  logic [3:0] allocBlock, gcVictim, rotOldBase, rotNewBase;
  logic [1:0] allocPage;

  hot_pool_mgr #(
    .TOTAL_BLOCKS(T), .OVERPROV_BLOCKS(N), .POOL_BLOCKS(N),
    .PAGES_PER_BLOCK(PPB), .PE_INTERVAL(INT), .BASE_INIT(B0)
  ) i_hot_pool_mgr (
    .clk(clk), .rstN(rstN), .allocReq(allocReq), .allocGnt(allocGnt),
    .allocBlock(allocBlock), .allocPage(allocPage), .gcReq(gcReq),
    .gcVictim(gcVictim), .eraseDone(eraseDone), .refreshPhase(refreshPhase),
    .rotReq(rotReq), .rotOldBase(rotOldBase), .rotNewBase(rotNewBase),
    .rotPending(rotPending), .rotAck(rotAck)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  int mWr, mPage, mGc, mFull, mPe, mBase, mPend, grants, pendAge;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One clock: drive at negedge, update model at posedge, compare at negedge
  task automatic step(bit req, bit ers, bit ack, bit ph);
    bit g, ea, fire, cm, adv, wrapped, idleErase;
    int eBlk, ePage;
    allocReq = req; eraseDone = ers; rotAck = ack; refreshPhase = ph;
    @(posedge clk);
    g    = req && (mFull != N);
    ea   = ers && (mFull != 0);
    idleErase = ers && (mFull == 0);
    fire = ph && (mPe == INT) && (mPend == 0);
    cm   = ack && (mPend != 0);
    eBlk = (mBase + mWr) % T;
    ePage = mPage;
    wrapped = (mWr == 0) && (grants >= N * PPB);
    adv = 0;
    if (g) begin
      grants++;
      if (mPage == PPB - 1) begin mPage = 0; mWr = (mWr + 1) % N; adv = 1; end
      else mPage++;
    end
    mFull = mFull + (adv ? 1 : 0) - (ea ? 1 : 0);
    if (ea) mGc = (mGc + 1) % N;
    if (cm) begin mBase = (mBase + N) % T; mPe = ea ? 1 : 0; end
    else if (ea && mPe < INT) mPe++;
    if (fire) mPend = 1; else if (cm) mPend = 0;
    @(negedge clk);
    if (req && !g) check("R6", "stalled grant", allocGnt, 0);
    else           check("R2", "allocGnt", allocGnt, g);
    if (g) begin
      check(wrapped ? "R3" : "R2", "allocBlock", allocBlock, eBlk);
      check("R2", "allocPage", allocPage, ePage);
    end
    check("R5", "gcReq", gcReq,
          (mFull == N) || (mFull == N - 1 && mPage != 0));
    check(idleErase ? "R7" : "R4", "gcVictim", gcVictim, (mBase + mGc) % T);
    check(ph ? "R9" : "R8", "rotReq", rotReq, fire);
    check("R9", "rotPending", rotPending, mPend);
    check("R10", "rotOldBase", rotOldBase, mBase);
    check("R10", "rotNewBase", rotNewBase, (mBase + N) % T);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mWr = 0; mPage = 0; mGc = 0; mFull = 0; mPe = 0; mBase = B0; mPend = 0;
    grants = 0; pendAge = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1", "allocGnt", allocGnt, 0);
    check("R1", "rotReq", rotReq, 0);
    check("R1", "rotPending", rotPending, 0);
    check("R1", "gcReq", gcReq, 0);
    check("R1", "gcVictim", gcVictim, B0);
    step(1, 0, 0, 0);
    check("R1", "first block", allocBlock, B0);
    check("R1", "first page", allocPage, 0);
    // Fill the rest of the pool, then request while full (R6)
    for (int i = 1; i < N * PPB; i++) step(1, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0);
    // Drain every full block, then an erase with nothing full (R7)
    for (int i = 0; i < N; i++) step(0, 1, 0, 0);
    step(0, 1, 0, 0);
    step(0, 1, 0, 0);
    // Mixed traffic in the pre-refresh phase; count saturates (R8)
    for (int i = 0; i < 200; i++)
      step(i % 5 != 2, ((i / 50) % 2 == 0) ? (i % 9 == 0) : (i % 2 == 0), 0, 0);
    // Stray acknowledge with nothing pending (R10)
    step(0, 0, 1, 0);
    // Refresh phase: repeated pool moves, stalls and coincident events
    for (int i = 0; i < 900; i++) begin
      bit ack;
      ack = (mPend != 0 && pendAge >= 2) || (i % 50 == 17);
      pendAge = (mPend != 0) ? pendAge + 1 : 0;
      step(i % 7 != 3,
           ((i / 100) % 2 == 0) ? ((i % 3 == 0) || (i % 11 == 5)) : (i % 8 == 0),
           ack, 1);
      if (ack) pendAge = 0;
    end
    // Back to pre-refresh: no further move requests (R8)
    for (int i = 0; i < 40; i++) step(1, i % 2 == 0, mPend != 0, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule